// File: doc/BRIEF.md
# Windowed Edge-Count FSK Bit Slicer

This block recovers binary data from a one-bit stream that carries one of two tones. The stream has already been sampled down, so the low tone sits near 15 kHz and the high tone near 35 kHz, and symbols arrive at 1 kbit/s. The block brings the stream into the clock domain, finds its rising transitions, and counts them over a window of exactly one symbol time. The window length is set in system clocks by `CLK_HZ / SYM_HZ`. At the end of each window the total is compared with a threshold. A total above the threshold means the high tone and yields a 0. Any other total means the low tone and yields a 1.

The window runs freely from reset. The `win_align` input restarts it whenever external symbol timing is known, which lets the window be lined up with the symbols. A small two-state controller sequences the decisions. `ST_COUNT` is the normal state and accumulates edges. When a window ends and no restart is present in that cycle, the transition *window_done* moves the controller to `ST_EMIT`. There it presents the new bit with a one-cycle strobe. The transition *strobe_done* returns it to `ST_COUNT` on the next cycle. The transition *realign*, taken on `win_align` from either state, forces `ST_COUNT` and drops the window in progress.

Top module: `fskd_edge_demod`

## Requirements
- R1: During reset and in the first cycle after it, `bit_valid` is 0 and `bit_out` is 0.
- R2: A window that counted at most `THRESH` rising edges (default 25) yields `bit_out` = 1. This includes a count of zero and a count exactly equal to the threshold.
- R3: A window that counted more than `THRESH` rising edges yields `bit_out` = 0. This includes `THRESH`+1.
- R4: With no `win_align`, one decision is made per window. `bit_valid` is high for exactly one cycle, and consecutive strobes are exactly `CLK_HZ/SYM_HZ` cycles apart.
- R5: A rising edge that is detected in the last cycle of a window is counted in the following window. It is counted exactly once.
- R6: `win_align` high in a cycle restarts the window and discards the edges counted so far. No decision is produced for the interrupted window, even when the restart falls on the window's last cycle. The next strobe comes `CLK_HZ/SYM_HZ`+1 cycles after the restart cycle.
- R7: Only low-to-high transitions of `din` are counted, after a two-flop synchronizer. Falling transitions and steady levels add nothing.
- R8: `bit_out` changes only in a cycle where `bit_valid` is high, and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | One-bit tone stream, asynchronous to `clk` |
| win_align | input | 1 | Synchronous pulse that restarts the counting window |
| bit_out | output | 1 | Decided data bit (1 = low tone, 0 = high tone) |
| bit_valid | output | 1 | One-cycle strobe marking a new `bit_out` |

## Verification
The bench targets the threshold boundary by placing exactly 25 and 26 edges in a window. A compare that used the wrong sense, or that was off by one, would flip one of those two bits. It places one rising edge precisely on a window's last cycle and follows it with a second window. A design that lost the edge would give 1 for the second window, and one that counted it twice would give 0 for the first. It restarts the window in the middle of a window and again on the terminal cycle. A design that kept the stale count, or that still emitted the interrupted decision, would show a wrong bit or an extra strobe. A low-tone window also catches a design that counts both edges, because that design would double the total and decide 0.

// File: rtl/fskd_pkg.sv
package fskd_pkg;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_EMIT  = 1'b1
    } demod_state_e;

    // High tone (count above threshold) maps to 0, low tone to 1.
    function automatic logic slice_bit(input logic above_thr);
        return ~above_thr;
    endfunction

endpackage

// File: rtl/fskd_in_sync.sv
module fskd_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its delayed copy.
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], din};
        end
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/fskd_win_timer.sv
module fskd_win_timer #(
    parameter int WIN_CLKS = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic last
);
    localparam int TW = (WIN_CLKS > 2) ? $clog2(WIN_CLKS) : 1;
    localparam logic [TW-1:0] TC_VAL = TW'(WIN_CLKS - 1);

    logic [TW-1:0] tick;

    assign last = (tick == TC_VAL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
        end else if (restart || last) begin
            tick <= '0;
        end else begin
            tick <= tick + 1'b1;
        end
    end
endmodule

// File: rtl/fskd_edge_tally.sv
module fskd_edge_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            // An edge seen in the clearing cycle opens the next window's total.
            count <= {{(CNT_W-1){1'b0}}, rise};
        end else if (rise && (count != {CNT_W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/fskd_edge_demod.sv
module fskd_edge_demod
    import fskd_pkg::*;
#(
    parameter int CLK_HZ      = 250_000_000,
    parameter int SYM_HZ      = 1000,
    parameter int THRESH      = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic win_align,
    output logic bit_out,
    output logic bit_valid
);
    localparam int WIN_CLKS = CLK_HZ / SYM_HZ;
    localparam int CNT_W    = $clog2(WIN_CLKS / 2 + 2);
    localparam logic [CNT_W:0] THR_V = (CNT_W + 1)'(THRESH);

    logic             rise;
    logic             win_last;
    logic             win_done;
    logic [CNT_W-1:0] edge_count;
    logic             bit_q;
    demod_state_e     state, state_nx;

    fskd_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .rise  (rise)
    );

    fskd_win_timer #(.WIN_CLKS(WIN_CLKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (win_align),
        .last    (win_last)
    );

    fskd_edge_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise),
        .clear (win_last | win_align),
        .count (edge_count)
    );

    // A restart in the terminal cycle cancels that window's decision.
    assign win_done = win_last & ~win_align;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_COUNT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COUNT: begin
                if (win_done) state_nx = ST_EMIT;       // window_done
            end
            ST_EMIT: begin
                state_nx = ST_COUNT;                     // strobe_done
            end
        endcase
        if (win_align) state_nx = ST_COUNT;             // realign
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (win_done) begin
            bit_q <= slice_bit({1'b0, edge_count} > THR_V);
        end
    end

    always_comb begin
        bit_valid = (state == ST_EMIT);
        bit_out   = bit_q;
    end
endmodule

// File: rtl/fskd_edge_demod_chk.sv
module fskd_edge_demod_chk #(
    parameter int WIN_CLKS = 250000
) (
    input logic clk,
    input logic rst_n,
    input logic win_align,
    input logic bit_out,
    input logic bit_valid
);
    localparam int GW = $clog2(WIN_CLKS + 2) + 1;

    logic [GW-1:0] gap;
    logic          armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap   <= '0;
            armed <= 1'b1;
        end else if (win_align) begin
            gap   <= '0;
            armed <= 1'b1;
        end else if (bit_valid) begin
            gap   <= GW'(1);
            armed <= 1'b1;
        end else if (gap != {GW{1'b1}}) begin
            gap <= gap + 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bit_valid && !bit_out));

    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    a_r4_window_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && armed) |-> (gap == GW'(WIN_CLKS)));

    a_r6_align_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        win_align |=> !bit_valid);

    a_r8_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> $stable(bit_out));
endmodule

bind fskd_edge_demod fskd_edge_demod_chk #(.WIN_CLKS(WIN_CLKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_align (win_align),
    .bit_out   (bit_out),
    .bit_valid (bit_valid)
);

// File: tb/fskd_edge_demod_tb.sv
`timescale 1ns/1ps
module fskd_edge_demod_tb;
    localparam int WIN = 400;
    localparam int OFF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic win_align = 1'b0;
    logic bit_out;
    logic bit_valid;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    bit    exp_bit_q[$];
    string exp_tag_q[$];

    always #2 clk = ~clk;

    fskd_edge_demod #(
        .CLK_HZ(400_000), .SYM_HZ(1000), .THRESH(25), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .win_align(win_align),
        .bit_out(bit_out), .bit_valid(bit_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic expect_bit(input bit b, input string tag);
        exp_bit_q.push_back(b);
        exp_tag_q.push_back(tag);
    endtask

    // Drives len negedge slots: n pulses of period per from OFF, optional
    // extra rise timed to land on the window's terminal cycle, optional align.
    task automatic drive_span(input int n, input int per, input int len,
                              input bit extra, input bit align_end);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i >= OFF && i < OFF + n * per)
                din = (((i - OFF) % per) < (per / 2));
            else if (extra && i >= WIN - 3 && i < WIN - 1)
                din = 1'b1;
            else
                din = 1'b0;
            win_align = align_end && (i == len - 1);
        end
    endtask

    // Scoreboard monitor
    always @(posedge clk) begin : mon
        static bit prev_v = 1'b0;
        static bit have_prev = 1'b0;
        static int last_cyc = 0;
        #1;
        cyc++;
        if (!rst_n) begin
            have_prev = 1'b0;
            prev_v = 1'b0;
        end else begin
            if (win_align) have_prev = 1'b0;
            if (bit_valid) begin
                check(!prev_v, "R4 strobe width", 2, 1);
                if (have_prev) check(cyc - last_cyc == WIN, "R4 strobe spacing", cyc - last_cyc, WIN);
                have_prev = 1'b1;
                last_cyc = cyc;
                if (exp_bit_q.size() == 0) begin
                    check(1'b0, "R6 unexpected strobe", 1, 0);
                end else begin
                    automatic bit    eb = exp_bit_q.pop_front();
                    automatic string et = exp_tag_q.pop_front();
                    check(bit_out == eb, et, bit_out, eb);
                end
            end
            prev_v = bit_valid;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        check(bit_valid == 1'b0, "R1 valid in reset", bit_valid, 0);
        check(bit_out == 1'b0, "R1 bit in reset", bit_out, 0);
        rst_n = 1'b1;
        win_align = 1'b1;
        @(posedge clk); #1;
        check(bit_valid == 1'b0 && bit_out == 1'b0, "R1 first cycle", bit_valid, 0);

        expect_bit(1'b1, "R2 R7 low tone 15 edges");
        drive_span(15, 24, WIN, 1'b0, 1'b0);
        expect_bit(1'b0, "R3 high tone 35 edges");
        drive_span(35, 10, WIN, 1'b0, 1'b0);
        expect_bit(1'b1, "R2 count equal threshold");
        drive_span(25, 14, WIN, 1'b0, 1'b0);
        expect_bit(1'b0, "R3 count threshold plus one");
        drive_span(26, 14, WIN, 1'b0, 1'b0);
        expect_bit(1'b1, "R2 zero edges");
        drive_span(0, 10, WIN, 1'b0, 1'b0);
        expect_bit(1'b0, "R3 38 edges");
        drive_span(38, 10, WIN, 1'b0, 1'b0);

        expect_bit(1'b1, "R5 terminal edge not in this window");
        drive_span(25, 14, WIN, 1'b1, 1'b0);
        expect_bit(1'b0, "R5 terminal edge carried over");
        drive_span(25, 14, WIN, 1'b0, 1'b0);

        // Restart in mid-window after 28 edges; stale count must be discarded.
        drive_span(28, 10, 300, 1'b0, 1'b1);
        expect_bit(1'b1, "R6 count cleared by align");
        drive_span(10, 24, WIN, 1'b0, 1'b0);

        // Restart on the terminal cycle of a high-tone window: no decision.
        drive_span(30, 10, WIN, 1'b0, 1'b1);
        expect_bit(1'b1, "R6 window after terminal align");
        drive_span(20, 14, WIN, 1'b0, 1'b0);
        expect_bit(1'b0, "R4 free-running next window");
        drive_span(35, 10, WIN, 1'b0, 1'b0);

        repeat (20) @(negedge clk);
        check(exp_bit_q.size() == 0, "R4 all decisions delivered", exp_bit_q.size(), 0);
        check(bit_out == 1'b0, "R8 bit held after last strobe", bit_out, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule